// File: doc/BRIEF.md
# Sample Memory Fetch Controller

This block keeps a delta-modulation playback channel supplied with one-byte samples. Software programs three registers: a flag register, a start-address register and a length register. It then starts or stops the channel with an enable strobe. The block keeps a running address and a count of the bytes still to fetch. It raises a level request toward an external memory arbiter. When the arbiter returns a byte with a valid strobe, the block places it in a single-byte sample buffer.

The output unit sees whether the buffer is full and takes the byte with a strobe. Taking the byte makes the block request the next one while bytes remain. When a sample runs out, the block either restarts it from the programmed start or, if looping is off, raises an interrupt. The interrupt is raised only when the flag register enables it.

The register values are coarse. The start register selects a 64-byte-aligned address in the top quarter of the 16-bit space. The length register selects a multiple of 16 bytes plus one. Addresses that run off the top of the space continue in the upper half. After the channel is started, the first request waits two or three cycles, depending on whether the start fell on an even or an odd system cycle.

Top module: `sample_fetch_ctrl`

## Requirements
- R1: A write with wrSel=1 sets the start register to 0xC000 OR (wrData shifted left by 6). That value is copied to dmaAddr the next time the channel is started or a looped sample restarts.
- R2: A write with wrSel=2 sets the reload count to (wrData shifted left by 4) plus 1. That value is copied to bytesLeft on the same occasions as R1.
- R3: A cycle with dmaValid high while bytesLeft is nonzero has these effects on the next cycle: bufData holds dmaData, bufFull is 1, dmaAddr is one higher and bytesLeft is one lower. While bytesLeft is zero, dmaValid has no effect on bufData, bufFull, dmaAddr or bytesLeft.
- R4: A byte accepted at dmaAddr 0xFFFF leaves dmaAddr at 0x8000.
- R5: When the last byte is accepted (bytesLeft 1 to 0) and the loop flag is set, dmaAddr and bytesLeft reload from the start and reload-count registers, and no interrupt is raised. When the loop flag is clear, irqPending becomes 1 if the IRQ-enable flag is set.
- R6: A write with wrSel=0 sets the IRQ-enable flag from wrData bit 7 and the loop flag from bit 6. If bit 7 is 0, the write also clears irqPending.
- R7: A chanWr with chanEn=0 forces bytesLeft to 0. Any chanWr, whatever the value of chanEn, clears irqPending.
- R8: A chanWr with chanEn=1 while bytesLeft is 0 reloads dmaAddr and bytesLeft. It leaves them unchanged when bytesLeft is nonzero. dmaReq rises 2 cycles after the start cycle if oddCycle was 0 in that cycle, or 3 cycles after if it was 1. dmaReq rises only if, in the cycle before it would rise, the buffer is empty and bytesLeft is nonzero.
- R9: After the active-low rstN reset, dmaAddr is 0xC000 and the reload count is 1. After the softRst strobe, both are 0. Both resets clear the flags, irqPending, bufFull, bufData, dmaReq, bytesLeft and the start register.
- R10: dmaReq stays high until a cycle with dmaValid high. It is low in the cycle after that.
- R11: irqAck clears irqPending. If an interrupt is raised in the same cycle as irqAck, a clearing flag write or a chanWr, the raise wins and irqPending is 1.
- R12: bufTake while bufFull is 1 empties the buffer. If bytesLeft is nonzero, dmaReq is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, synchronous |
| softRst | input | 1 | Soft reset strobe, synchronous |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 flags, 1 start, 2 length, 3 none |
| wrData | input | 8 | Register write data |
| chanWr | input | 1 | Channel enable/disable strobe |
| chanEn | input | 1 | Value carried by chanWr: 1 start, 0 stop |
| oddCycle | input | 1 | Parity of the current system cycle |
| dmaValid | input | 1 | Returned byte valid |
| dmaData | input | 8 | Returned byte |
| bufTake | input | 1 | Output unit takes the buffered byte |
| irqAck | input | 1 | Interrupt acknowledge |
| dmaReq | output | 1 | Fetch request level |
| dmaAddr | output | 16 | Address of the next fetch |
| bytesLeft | output | 12 | Bytes still to fetch |
| bufData | output | 8 | Sample buffer contents |
| bufFull | output | 1 | Sample buffer holds an unread byte |
| irqPending | output | 1 | Sample-end interrupt pending |

## Verification
The two functions that can collide are the end-of-sample interrupt raise and the interrupt clear, which comes from an acknowledge, a flag write or a channel strobe. The bench delivers the final byte of a non-looping sample in the same cycle as irqAck and expects irqPending to be 1 on the next cycle. It then checks that each clearing source, applied alone, drops the flag. A second overlap is also driven: the wrap at the top of memory falls in the cycle before the final byte. The bench judges it by the address and count after each of those two bytes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_START = 2'd1;
  localparam logic [SEL_W-1:0] SEL_LEN   = 2'd2;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic softRst;
    logic loadStart;
    logic loadLen;
    logic reload;
    logic accept;
    logic clearCount;
    logic take;
  } strobe_t;
endpackage

// File: rtl/sfc_datapath.sv
module sfc_datapath #(
  parameter int ADDR_W = 16,
  parameter int CNT_W = 12,
  parameter int DATA_W = 8,
  parameter int START_SHIFT = 6,
  parameter int LEN_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfc_pkg::strobe_t  stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] dmaData,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              countZero,
  output logic              countOne
);
  localparam logic [ADDR_W-1:0] BASE_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] WRAP_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  ONE_CNT   = CNT_W'(1);

  logic [ADDR_W-1:0] startAddr;
  logic [CNT_W-1:0]  lenLoad;
  logic [ADDR_W-1:0] startMapped;
  logic [CNT_W-1:0]  lenMapped;
  logic [ADDR_W-1:0] addrInc;

  assign startMapped = BASE_ADDR | (ADDR_W'(wrData) << START_SHIFT);
  assign lenMapped   = (CNT_W'(wrData) << LEN_SHIFT) + ONE_CNT;
  assign addrInc     = (addr == '1) ? WRAP_ADDR : addr + ADDR_W'(1);
  assign countZero   = (count == '0);
  assign countOne    = (count == ONE_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr      <= BASE_ADDR;
      lenLoad   <= ONE_CNT;
      startAddr <= '0;
      count     <= '0;
      bufData   <= '0;
      bufFull   <= 1'b0;
    end else if (stb.softRst) begin
      addr      <= '0;
      lenLoad   <= '0;
      startAddr <= '0;
      count     <= '0;
      bufData   <= '0;
      bufFull   <= 1'b0;
    end else begin
      if (stb.loadStart) startAddr <= startMapped;
      if (stb.loadLen)   lenLoad   <= lenMapped;
      if (stb.reload)      addr <= startAddr;
      else if (stb.accept) addr <= addrInc;
      if (stb.clearCount)  count <= '0;
      else if (stb.reload) count <= lenLoad;
      else if (stb.accept) count <= count - ONE_CNT;
      if (stb.accept) begin
        bufData <= dmaData;
        bufFull <= 1'b1;
      end else if (stb.take) begin
        bufFull <= 1'b0;
      end
    end
  end

  // R1: a mapped start address is aligned and sits in the top quarter
  assert_start_map_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStart && !stb.softRst |=> startAddr[ADDR_W-1 -: 2] == 2'b11 && startAddr[START_SHIFT-1:0] == '0);

  // R2: a mapped reload count is a multiple of sixteen plus one
  assert_len_map_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadLen && !stb.softRst |=> lenLoad[LEN_SHIFT-1:0] == LEN_SHIFT'(1));

  // R3: an accepted byte consumes exactly one count
  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept && !stb.reload && !stb.clearCount && !stb.softRst |=> count == $past(count) - ONE_CNT && bufFull);

  // R4: stepping past the top lands in the upper half
  assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept && !stb.reload && !stb.softRst && $past(rstN) && addr == '1 |=> addr == WRAP_ADDR);
endmodule

// File: rtl/sfc_control.sv
module sfc_control #(
  parameter int DATA_W = 8,
  parameter int INIT_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      softRst,
  input  logic                      wrEn,
  input  logic [sfc_pkg::SEL_W-1:0] wrSel,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      chanWr,
  input  logic                      chanEn,
  input  logic                      oddCycle,
  input  logic                      dmaValid,
  input  logic                      bufTake,
  input  logic                      irqAck,
  input  logic                      countZero,
  input  logic                      countOne,
  input  logic                      bufFull,
  output sfc_pkg::strobe_t          stb,
  output logic                      dmaReq,
  output logic                      irqPending
);
  import sfc_pkg::*;

  localparam logic [INIT_W-1:0] DELAY_EVEN = INIT_W'(2);
  localparam logic [INIT_W-1:0] DELAY_ODD  = INIT_W'(3);
  localparam logic [INIT_W-1:0] DELAY_LAST = INIT_W'(1);

  logic irqEn;
  logic loopFlag;
  logic [INIT_W-1:0] initCnt;
  logic flagsWr;
  logic lastByte;
  logic enStart;
  logic irqSet;
  logic irqClr;
  logic reqSet;

  assign flagsWr  = wrEn && (wrSel == SEL_FLAGS);
  assign enStart  = chanWr && chanEn && countZero;

  always_comb begin
    stb            = '0;
    stb.softRst    = softRst;
    stb.loadStart  = wrEn && (wrSel == SEL_START);
    stb.loadLen    = wrEn && (wrSel == SEL_LEN);
    stb.accept     = dmaValid && !countZero;
    stb.take       = bufTake && bufFull;
    stb.clearCount = chanWr && !chanEn;
    stb.reload     = enStart || (dmaValid && !countZero && countOne && loopFlag);
  end

  assign lastByte = stb.accept && countOne;
  assign irqSet   = lastByte && !loopFlag && irqEn;
  assign irqClr   = irqAck || chanWr || (flagsWr && !wrData[DATA_W-1]);
  assign reqSet   = !countZero && ((initCnt == DELAY_LAST && !bufFull) || stb.take);

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      irqEn      <= 1'b0;
      loopFlag   <= 1'b0;
      irqPending <= 1'b0;
      initCnt    <= '0;
      dmaReq     <= 1'b0;
    end else begin
      if (flagsWr) begin
        irqEn    <= wrData[DATA_W-1];
        loopFlag <= wrData[DATA_W-2];
      end
      if (irqSet)      irqPending <= 1'b1;
      else if (irqClr) irqPending <= 1'b0;
      if (enStart)              initCnt <= oddCycle ? DELAY_ODD : DELAY_EVEN;
      else if (initCnt != '0)   initCnt <= initCnt - DELAY_LAST;
      if (dmaValid)    dmaReq <= 1'b0;
      else if (reqSet) dmaReq <= 1'b1;
    end
  end

  // R10: a returned byte always drops the request
  assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |=> !dmaReq);

  // R5 and R11: an end-of-sample raise wins over every clear
  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqSet && !softRst |=> irqPending);

  // R11: acknowledge without a raise empties the flag
  assert_irq_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqAck && !irqSet |=> !irqPending);

  // R7: stopping the channel empties the count
  assert_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
    chanWr && !chanEn && !softRst |=> countZero);

  // R12: taking a byte with bytes left requests another
  assert_take_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    bufTake && bufFull && !countZero && !dmaValid && !softRst |=> dmaReq && !bufFull);
endmodule

// File: rtl/sample_fetch_ctrl.sv
module sample_fetch_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      softRst,
  input  logic                      wrEn,
  input  logic [sfc_pkg::SEL_W-1:0] wrSel,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      chanWr,
  input  logic                      chanEn,
  input  logic                      oddCycle,
  input  logic                      dmaValid,
  input  logic [DATA_W-1:0]         dmaData,
  input  logic                      bufTake,
  input  logic                      irqAck,
  output logic                      dmaReq,
  output logic [ADDR_W-1:0]         dmaAddr,
  output logic [CNT_W-1:0]          bytesLeft,
  output logic [DATA_W-1:0]         bufData,
  output logic                      bufFull,
  output logic                      irqPending
);
  sfc_pkg::strobe_t stb;
  logic countZero;
  logic countOne;

  sfc_control #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .chanWr(chanWr), .chanEn(chanEn), .oddCycle(oddCycle),
    .dmaValid(dmaValid), .bufTake(bufTake), .irqAck(irqAck),
    .countZero(countZero), .countOne(countOne), .bufFull(bufFull),
    .stb(stb), .dmaReq(dmaReq), .irqPending(irqPending)
  );

  sfc_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrData(wrData), .dmaData(dmaData),
    .addr(dmaAddr), .count(bytesLeft),
    .bufData(bufData), .bufFull(bufFull),
    .countZero(countZero), .countOne(countOne)
  );
endmodule

// File: tb/sim_sample_fetch_ctrl.sv
module sim_sample_fetch_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd3;
  logic [7:0] wrData = '0;
  logic chanWr = 1'b0;
  logic chanEn = 1'b0;
  logic oddCycle = 1'b0;
  logic dmaValid = 1'b0;
  logic [7:0] dmaData = '0;
  logic bufTake = 1'b0;
  logic irqAck = 1'b0;
  logic dmaReq;
  logic [15:0] dmaAddr;
  logic [11:0] bytesLeft;
  logic [7:0] bufData;
  logic bufFull;
  logic irqPending;

  int errors = 0;
  int checks = 0;

  sample_fetch_ctrl u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .chanWr(chanWr), .chanEn(chanEn), .oddCycle(oddCycle),
    .dmaValid(dmaValid), .dmaData(dmaData), .bufTake(bufTake), .irqAck(irqAck),
    .dmaReq(dmaReq), .dmaAddr(dmaAddr), .bytesLeft(bytesLeft),
    .bufData(bufData), .bufFull(bufFull), .irqPending(irqPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Inputs change only at the falling edge; outputs are read there too.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    tick();
    wrEn = 1'b0; wrSel = 2'd3;
  endtask

  task automatic chan(input logic en, input logic odd);
    chanWr = 1'b1; chanEn = en; oddCycle = odd;
    tick();
    chanWr = 1'b0; oddCycle = 1'b0;
  endtask

  task automatic feed(input logic [7:0] val, input logic ack);
    dmaValid = 1'b1; dmaData = val; irqAck = ack;
    tick();
    dmaValid = 1'b0; irqAck = 1'b0;
  endtask

  task automatic hardReset();
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
  endtask

  task automatic testHardReset();
    hardReset();
    check("R9 hard addr", dmaAddr, 16'hC000);
    check("R9 hard count", bytesLeft, 0);
    check("R9 hard full", bufFull, 0);
    check("R9 hard req", dmaReq, 0);
    check("R9 hard irq", irqPending, 0);
    chan(1'b1, 1'b0);
    check("R9 length one", bytesLeft, 1);
    check("R9 start cleared", dmaAddr, 16'h0000);
    feed(8'h11, 1'b0);
    check("R3 addr step", dmaAddr, 16'h0001);
    check("R3 count step", bytesLeft, 0);
  endtask

  task automatic testMapAndDelay();
    hardReset();
    writeReg(2'd1, 8'h12);
    writeReg(2'd2, 8'h03);
    chan(1'b1, 1'b0);
    check("R1 start map", dmaAddr, 16'hC480);
    check("R2 length map", bytesLeft, 49);
    check("R8 even delay 0", dmaReq, 0);
    tick();
    check("R8 even delay 1", dmaReq, 0);
    tick();
    check("R8 even delay 2", dmaReq, 1);
    tick();
    check("R10 held", dmaReq, 1);
    feed(8'hA5, 1'b0);
    check("R10 dropped", dmaReq, 0);
    check("R3 data", bufData, 8'hA5);
    check("R3 full", bufFull, 1);
    check("R3 addr", dmaAddr, 16'hC481);
    check("R3 count", bytesLeft, 48);
    bufTake = 1'b1;
    tick();
    bufTake = 1'b0;
    check("R12 emptied", bufFull, 0);
    check("R12 request", dmaReq, 1);
  endtask

  task automatic testWrapAndCollision();
    hardReset();
    writeReg(2'd0, 8'h80);
    writeReg(2'd1, 8'hFF);
    writeReg(2'd2, 8'h04);
    chan(1'b1, 1'b0);
    check("R1 top start", dmaAddr, 16'hFFC0);
    check("R2 count 65", bytesLeft, 65);
    for (int i = 0; i < 63; i++) feed(8'(i), 1'b0);
    check("R4 at top", dmaAddr, 16'hFFFF);
    feed(8'h3F, 1'b0);
    check("R4 wrapped", dmaAddr, 16'h8000);
    check("R4 count", bytesLeft, 1);
    check("R5 no early irq", irqPending, 0);
    feed(8'h77, 1'b1);
    check("R11 raise beats ack", irqPending, 1);
    check("R5 count zero", bytesLeft, 0);
    check("R5 addr after", dmaAddr, 16'h8001);
    writeReg(2'd0, 8'hC0);
    check("R6 bit7 set keeps", irqPending, 1);
    chan(1'b0, 1'b0);
    check("R7 chanWr clears", irqPending, 0);
    // buffer still full here: start must not request
    chan(1'b1, 1'b1);
    check("R8 reload count", bytesLeft, 65);
    tick(); tick(); tick();
    check("R8 full no req", dmaReq, 0);
    writeReg(2'd1, 8'h00);
    chan(1'b1, 1'b0);
    check("R8 busy no reload", dmaAddr, 16'hFFC0);
    chan(1'b0, 1'b0);
    check("R7 count forced", bytesLeft, 0);
    feed(8'h5A, 1'b0);
    check("R3 ignored data", bufData, 8'h77);
    check("R3 ignored addr", dmaAddr, 16'hFFC0);
  endtask

  task automatic testOddDelay();
    hardReset();
    writeReg(2'd2, 8'h01);
    chan(1'b1, 1'b1);
    tick();
    check("R8 odd delay 1", dmaReq, 0);
    tick();
    check("R8 odd delay 2", dmaReq, 0);
    tick();
    check("R8 odd delay 3", dmaReq, 1);
  endtask

  task automatic testIrqClears();
    hardReset();
    writeReg(2'd0, 8'h80);
    writeReg(2'd2, 8'h00);
    chan(1'b1, 1'b0);
    feed(8'h01, 1'b0);
    check("R5 irq raised", irqPending, 1);
    writeReg(2'd0, 8'h00);
    check("R6 flag clear", irqPending, 0);
    writeReg(2'd0, 8'h80);
    chan(1'b1, 1'b0);
    feed(8'h02, 1'b0);
    check("R5 irq again", irqPending, 1);
    irqAck = 1'b1;
    tick();
    irqAck = 1'b0;
    check("R11 ack clears", irqPending, 0);
  endtask

  task automatic testLoop();
    hardReset();
    writeReg(2'd0, 8'hC0);
    writeReg(2'd1, 8'h01);
    writeReg(2'd2, 8'h00);
    chan(1'b1, 1'b0);
    check("R1 start 0x01", dmaAddr, 16'hC040);
    feed(8'h33, 1'b0);
    check("R5 loop count", bytesLeft, 1);
    check("R5 loop addr", dmaAddr, 16'hC040);
    check("R5 loop no irq", irqPending, 0);
    check("R6 loop full", bufFull, 1);
  endtask

  task automatic testSoftReset();
    softRst = 1'b1;
    tick();
    softRst = 1'b0;
    check("R9 soft addr", dmaAddr, 16'h0000);
    check("R9 soft full", bufFull, 0);
    check("R9 soft data", bufData, 0);
    chan(1'b1, 1'b0);
    check("R9 soft length", bytesLeft, 0);
    tick(); tick();
    check("R9 soft no req", dmaReq, 0);
  endtask

  initial begin
    rstN = 1'b0;
    tick();
    testHardReset();
    testMapAndDelay();
    testWrapAndCollision();
    testOddDelay();
    testIrqClears();
    testLoop();
    testSoftReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule